// File: doc/BRIEF.md
# Burst-of-Two DDR SRAM Command Controller

This block sits between an on-chip request stream and an external common-I/O SRAM that moves two data words per command on both edges of its input clock. The controller runs from a single clock at twice the memory clock rate. An internal phase flag splits that clock into two alternating half-cycle slots. The first slot after reset, and every second slot after it, is the rising-edge slot, where commands are presented. The slots in between are the falling-edge slots. Each accepted user request becomes exactly one memory command. A write supplies both data words and a lane mask for each word. A read returns both words together on a single-cycle valid pulse.

On the memory side the controller drives an active-low command strobe, a read/write select, the address, the per-lane write enables and the outgoing data bus with its output enable. Returning read data arrives on a separate input bus. Write data is scheduled one memory clock behind its command. Read data is captured after a fixed number of slots set by a parameter. Whenever the command type changes, the controller inserts idle command slots so that the controller and the memory never drive the shared bus at the same time.

Back-pressure rules for the request stream: a request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only in a falling-edge slot, so a waiting request is never held for more than two cycles by phase alone. `req_ready` also depends on `req_write`. It stays low while the offered request has the opposite type to the last command and the turnaround window has not yet elapsed. A request must therefore hold all of its fields stable until it is accepted. There is no back-pressure on responses: the user must take `rsp_valid` when it is presented.

Top module: `ddrb2_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `mem_strobe_n` is 1, `mem_dq_oe` is 0, `mem_lane_we` is all zero, `rsp_valid` is 0 and `k_slot` is 1.
- R2: `k_slot` alternates every cycle. `req_ready` is never high while `k_slot` is high. With no earlier command, `req_ready` equals the inverse of `k_slot`.
- R3: A request accepted in cycle A appears as a command in cycle A+1, which is a `k_slot` cycle. In that cycle `mem_strobe_n` is 0, `mem_addr` is the request address, and `mem_rd_sel` is 1 for a read and 0 for a write. In every cycle with no command, including long idle stretches, `mem_strobe_n` is 1.
- R4: For a write accepted in cycle A, `mem_dq_oe` is 1 in cycles A+3 and A+4. `mem_dq_out` carries word 0 in cycle A+3 and word 1 in cycle A+4. `mem_dq_oe` is 0 in cycle A+2 and in cycle A+5 when no later write follows.
- R5: `mem_lane_we` bit i enables bits [9i+8:9i] of the word on the bus in that cycle. It carries the mask of word 0 in cycle A+3 and the mask of word 1 in cycle A+4. It is all zero whenever `mem_dq_oe` is 0. Lanes written with the enable at 0 keep their old contents.
- R6: For a read accepted in cycle A, `mem_dq_in` is sampled at the end of cycle A+1+RD_LAT as word 0 and at the end of cycle A+2+RD_LAT as word 1. `rsp_valid` is high in cycle A+RD_LAT+3 only, with both words presented together.
- R7: Requests of the same type that are offered back to back are accepted two cycles apart, so their commands occupy consecutive rising-edge slots.
- R8: When the command type changes, at least TURN_K idle rising-edge slots separate the two commands, where TURN_K = max(1, (RD_LAT-1)/2) using integer division. A waiting request sees `req_ready` low during that window and is then accepted at the first allowed slot, 2*(1+TURN_K) cycles after the previous acceptance.
- R9: Read responses come back in the order the reads were accepted.
- R10: `mem_dq_oe` is 0 in every cycle in which the memory returns read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, twice the memory clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken on this edge |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | AW | Burst address |
| req_wdata0 | input | DW | First write word |
| req_wdata1 | input | DW | Second write word |
| req_wmask0 | input | LANES | Lane enables for the first word |
| req_wmask1 | input | LANES | Lane enables for the second word |
| rsp_valid | output | 1 | One-cycle read response pulse |
| rsp_rdata0 | output | DW | First read word |
| rsp_rdata1 | output | DW | Second read word |
| k_slot | output | 1 | High in the rising-edge (command) slot |
| mem_strobe_n | output | 1 | Active-low command strobe |
| mem_rd_sel | output | 1 | 1 selects read, 0 selects write |
| mem_addr | output | AW | Memory address |
| mem_lane_we | output | LANES | Per-lane write enables, active high |
| mem_dq_out | output | DW | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the shared data bus |
| mem_dq_in | input | DW | Data returned from the memory |

## Verification
The bench builds the block with an 8-bit address, two 9-bit lanes and RD_LAT set to 5. That read latency makes the derived turnaround two idle command slots instead of one. It therefore exercises the saturating gap counter beyond a single step and stretches the read window, where bus contention would show. A behavioural memory in the bench answers reads after RD_LAT slots and merges writes lane by lane. This lets the read-after-write, lane-merge, ordering and turnaround cases be checked against expected values that the bench computes itself.

// File: rtl/ddrb2_pkg.sv
package ddrb2_pkg;

  // Half-cycle slot inside one memory clock period.
  typedef enum logic {
    SLOT_K  = 1'b0,
    SLOT_KN = 1'b1
  } slot_e;

  // Idle command slots needed between commands of different type so that
  // write data launched after a read never overlaps returning read data.
  function automatic int turn_k(input int rd_lat);
    int t;
    t = (rd_lat - 1) / 2;
    return (t < 1) ? 1 : t;
  endfunction

endpackage

// File: rtl/ddrb2_cmd_issue.sv
module ddrb2_cmd_issue
  import ddrb2_pkg::*;
#(
  parameter int AW     = 20,
  parameter int TURN_K = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  output logic          req_ready,
  output logic          cmd_fire,
  output logic          k_slot,
  output logic          mem_strobe_n,
  output logic          mem_rd_sel,
  output logic [AW-1:0] mem_addr
);

  localparam int GW = $clog2(TURN_K + 1);
  localparam logic [GW-1:0] GAP_FULL = GW'(TURN_K);

  slot_e         slot_q;
  logic          last_wr_q;
  logic [GW-1:0] gap_q;
  logic          same_kind;
  logic          gap_done;

  assign same_kind = (req_write == last_wr_q);
  assign gap_done  = (gap_q == GAP_FULL);
  // Accept only in the slot before a command slot; a type change waits for the gap.
  assign req_ready = (slot_q == SLOT_KN) && (same_kind || gap_done);
  assign cmd_fire  = req_valid && req_ready;
  assign k_slot    = (slot_q == SLOT_K);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q       <= SLOT_K;
      last_wr_q    <= 1'b0;
      gap_q        <= GAP_FULL;
      mem_strobe_n <= 1'b1;
      mem_rd_sel   <= 1'b1;
      mem_addr     <= '0;
    end else begin
      slot_q       <= (slot_q == SLOT_K) ? SLOT_KN : SLOT_K;
      mem_strobe_n <= !cmd_fire;
      mem_rd_sel   <= cmd_fire ? !req_write : 1'b1;
      if (cmd_fire) begin
        mem_addr  <= req_addr;
        last_wr_q <= req_write;
        gap_q     <= '0;
      end else if (slot_q == SLOT_KN && !gap_done) begin
        // Next slot is a command slot left empty: one more idle slot counted.
        gap_q <= gap_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ddrb2_wr_sched.sv
module ddrb2_wr_sched #(
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [LANES*LANE_W-1:0] wdata0,
  input  logic [LANES*LANE_W-1:0] wdata1,
  input  logic [LANES-1:0]        wmask0,
  input  logic [LANES-1:0]        wmask1,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_oe,
  output logic [LANES-1:0]        lane_we
);

  localparam int DW = LANES * LANE_W;

  typedef struct packed {
    logic [DW-1:0]    w0;
    logic [DW-1:0]    w1;
    logic [LANES-1:0] m0;
    logic [LANES-1:0] m1;
  } burst_t;

  burst_t           st0_q, st1_q;
  logic             st0_v, st1_v;
  logic             tail_v;
  logic [DW-1:0]    tail_w;
  logic [LANES-1:0] tail_m;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st0_v   <= 1'b0;
      st1_v   <= 1'b0;
      st0_q   <= '0;
      st1_q   <= '0;
      tail_v  <= 1'b0;
      tail_w  <= '0;
      tail_m  <= '0;
      dq_out  <= '0;
      dq_oe   <= 1'b0;
      lane_we <= '0;
    end else begin
      // Stage 0 covers the command slot, stage 1 the slot after it.
      st0_v <= load;
      if (load) st0_q <= '{w0: wdata0, w1: wdata1, m0: wmask0, m1: wmask1};
      st1_v <= st0_v;
      st1_q <= st0_q;
      if (st1_v) begin
        dq_out  <= st1_q.w0;
        lane_we <= st1_q.m0;
        dq_oe   <= 1'b1;
        tail_v  <= 1'b1;
        tail_w  <= st1_q.w1;
        tail_m  <= st1_q.m1;
      end else if (tail_v) begin
        dq_out  <= tail_w;
        lane_we <= tail_m;
        dq_oe   <= 1'b1;
        tail_v  <= 1'b0;
      end else begin
        lane_we <= '0;
        dq_oe   <= 1'b0;
        tail_v  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ddrb2_rd_capture.sv
module ddrb2_rd_capture #(
  parameter int DW     = 18,
  parameter int RD_LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [DW-1:0] mem_dq_in,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata0,
  output logic [DW-1:0] rsp_rdata1
);

  localparam int DEPTH = RD_LAT + 2;

  // Bit k is high during the k-th slot after a read command slot.
  logic [DEPTH-1:0] track_q;
  logic [DW-1:0]    first_q;

  always_ff @(posedge clk) begin
    if (!rst_n) track_q[0] <= 1'b0;
    else        track_q[0] <= issue;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_track
    always_ff @(posedge clk) begin
      if (!rst_n) track_q[i] <= 1'b0;
      else        track_q[i] <= track_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_q    <= '0;
      rsp_valid  <= 1'b0;
      rsp_rdata0 <= '0;
      rsp_rdata1 <= '0;
    end else begin
      if (track_q[RD_LAT]) first_q <= mem_dq_in;
      rsp_valid <= track_q[RD_LAT+1];
      if (track_q[RD_LAT+1]) begin
        rsp_rdata0 <= first_q;
        rsp_rdata1 <= mem_dq_in;
      end
    end
  end

endmodule

// File: rtl/ddrb2_ctrl.sv
module ddrb2_ctrl
  import ddrb2_pkg::*;
#(
  parameter int AW     = 20,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  parameter int RD_LAT = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [AW-1:0]           req_addr,
  input  logic [LANES*LANE_W-1:0] req_wdata0,
  input  logic [LANES*LANE_W-1:0] req_wdata1,
  input  logic [LANES-1:0]        req_wmask0,
  input  logic [LANES-1:0]        req_wmask1,
  output logic                    rsp_valid,
  output logic [LANES*LANE_W-1:0] rsp_rdata0,
  output logic [LANES*LANE_W-1:0] rsp_rdata1,
  output logic                    k_slot,
  output logic                    mem_strobe_n,
  output logic                    mem_rd_sel,
  output logic [AW-1:0]           mem_addr,
  output logic [LANES-1:0]        mem_lane_we,
  output logic [LANES*LANE_W-1:0] mem_dq_out,
  output logic                    mem_dq_oe,
  input  logic [LANES*LANE_W-1:0] mem_dq_in
);

  localparam int DW     = LANES * LANE_W;
  localparam int TURN_K = turn_k(RD_LAT);

  logic cmd_fire;
  logic wr_load;
  logic rd_issue;

  assign wr_load  = cmd_fire && req_write;
  assign rd_issue = cmd_fire && !req_write;

  ddrb2_cmd_issue #(.AW(AW), .TURN_K(TURN_K)) u_issue (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_ready    (req_ready),
    .cmd_fire     (cmd_fire),
    .k_slot       (k_slot),
    .mem_strobe_n (mem_strobe_n),
    .mem_rd_sel   (mem_rd_sel),
    .mem_addr     (mem_addr)
  );

  ddrb2_wr_sched #(.LANES(LANES), .LANE_W(LANE_W)) u_wr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (wr_load),
    .wdata0  (req_wdata0),
    .wdata1  (req_wdata1),
    .wmask0  (req_wmask0),
    .wmask1  (req_wmask1),
    .dq_out  (mem_dq_out),
    .dq_oe   (mem_dq_oe),
    .lane_we (mem_lane_we)
  );

  ddrb2_rd_capture #(.DW(DW), .RD_LAT(RD_LAT)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue      (rd_issue),
    .mem_dq_in  (mem_dq_in),
    .rsp_valid  (rsp_valid),
    .rsp_rdata0 (rsp_rdata0),
    .rsp_rdata1 (rsp_rdata1)
  );

endmodule

// File: rtl/ddrb2_ctrl_chk.sv
module ddrb2_ctrl_chk #(
  parameter int LANES  = 2,
  parameter int RD_LAT = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             k_slot,
  input logic             mem_strobe_n,
  input logic             mem_rd_sel,
  input logic [LANES-1:0] mem_lane_we,
  input logic             mem_dq_oe
);

  // Bit j high during slot j+1 after a read command slot.
  logic [RD_LAT:0] rd_win_q;
  logic            rd_cmd;
  logic            wr_cmd;

  assign rd_cmd = !mem_strobe_n && mem_rd_sel;
  assign wr_cmd = !mem_strobe_n && !mem_rd_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) rd_win_q <= '0;
    else        rd_win_q <= {rd_win_q[RD_LAT-1:0], rd_cmd};
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (mem_strobe_n && !mem_dq_oe && !rsp_valid && mem_lane_we == '0));

  assert_ready_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !k_slot);

  assert_k_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    k_slot |=> !k_slot);

  assert_kn_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !k_slot |=> k_slot);

  assert_strobe_in_k_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_strobe_n |-> k_slot);

  assert_accept_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !mem_strobe_n);

  assert_wr_beats_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd |-> ##2 mem_dq_oe ##1 mem_dq_oe);

  assert_lane_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_dq_oe |-> (mem_lane_we == '0));

  assert_rsp_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_rd_then_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd |-> ##2 !wr_cmd);

  assert_wr_then_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd |-> ##2 !rd_cmd);

  assert_bus_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_win_q[RD_LAT-1] || rd_win_q[RD_LAT]) |-> !mem_dq_oe);

endmodule

bind ddrb2_ctrl ddrb2_ctrl_chk #(.LANES(LANES), .RD_LAT(RD_LAT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .k_slot       (k_slot),
  .mem_strobe_n (mem_strobe_n),
  .mem_rd_sel   (mem_rd_sel),
  .mem_lane_we  (mem_lane_we),
  .mem_dq_oe    (mem_dq_oe)
);

// File: tb/ddrb2_ctrl_tb_top.sv
`timescale 1ns/1ps
module ddrb2_ctrl_tb_top;

  localparam int AW     = 8;
  localparam int LANES  = 2;
  localparam int LANE_W = 9;
  localparam int DW     = LANES * LANE_W;
  localparam int RD_LAT = 5;
  localparam int TURN   = 2;               // max(1, (5-1)/2)
  localparam int DIFF_GAP = 2 * (1 + TURN); // cycles between accepts of different type

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata0 = '0, req_wdata1 = '0;
  logic [LANES-1:0] req_wmask0 = '0, req_wmask1 = '0;
  logic rsp_valid;
  logic [DW-1:0] rsp_rdata0, rsp_rdata1;
  logic k_slot, mem_strobe_n, mem_rd_sel, mem_dq_oe;
  logic [AW-1:0] mem_addr;
  logic [LANES-1:0] mem_lane_we;
  logic [DW-1:0] mem_dq_out;
  logic [DW-1:0] mem_dq_in = '0;

  always #5 clk = ~clk;

  ddrb2_ctrl #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W), .RD_LAT(RD_LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata0(req_wdata0),
    .req_wdata1(req_wdata1), .req_wmask0(req_wmask0), .req_wmask1(req_wmask1),
    .rsp_valid(rsp_valid), .rsp_rdata0(rsp_rdata0), .rsp_rdata1(rsp_rdata1),
    .k_slot(k_slot), .mem_strobe_n(mem_strobe_n), .mem_rd_sel(mem_rd_sel),
    .mem_addr(mem_addr), .mem_lane_we(mem_lane_we), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
      input logic [DW-1:0] new_w, input logic [LANES-1:0] en);
    logic [DW-1:0] r;
    r = old_w;
    for (int i = 0; i < LANES; i++)
      if (en[i]) r[i*LANE_W +: LANE_W] = new_w[i*LANE_W +: LANE_W];
    return r;
  endfunction

  // Behavioural memory, bus log and response log.
  logic [DW-1:0] m0 [16];
  logic [DW-1:0] m1 [16];
  logic [DW-1:0] e0 [16];
  logic [DW-1:0] e1 [16];
  bit            sch_v [16];
  logic [DW-1:0] sch_d [16];
  int            wq_k [16];
  logic [3:0]    wq_a [16];
  logic          l_sn [64];
  logic          l_rd [64];
  logic [AW-1:0] l_addr [64];
  logic          l_oe [64];
  logic [DW-1:0] l_dq [64];
  logic [LANES-1:0] l_we [64];
  logic          l_rv [64];
  int            nr = 0;
  int            r_cyc [32];
  logic [DW-1:0] r_d0 [32];
  logic [DW-1:0] r_d1 [32];

  initial begin
    for (int i = 0; i < 16; i++) begin
      m0[i] = DW'(18'h0A000 + i * 17);
      m1[i] = DW'(18'h15000 + i * 29);
      e0[i] = m0[i];
      e1[i] = m1[i];
      sch_v[i] = 1'b0;
      sch_d[i] = '0;
      wq_k[i] = 0;
      wq_a[i] = '0;
    end
  end

  always @(negedge clk) begin
    int c, s;
    logic [3:0] a;
    c = cyc;
    s = c % 16;
    if (rst_n) begin
      // R10: no drive from the controller while read data is returning.
      if (sch_v[s]) chk(!mem_dq_oe, "R10", "oe during read return", 64'(mem_dq_oe), 64'd0);
      mem_dq_in = sch_v[s] ? sch_d[s] : '0;
      sch_v[s] = 1'b0;
      if (wq_k[s] != 0 && mem_dq_oe) begin
        a = wq_a[s];
        if (wq_k[s] == 1) m0[a] = merge(m0[a], mem_dq_out, mem_lane_we);
        else              m1[a] = merge(m1[a], mem_dq_out, mem_lane_we);
      end
      wq_k[s] = 0;
      if (!mem_strobe_n) begin
        a = mem_addr[3:0];
        if (mem_rd_sel) begin
          sch_v[(c + RD_LAT) % 16] = 1'b1;
          sch_d[(c + RD_LAT) % 16] = m0[a];
          sch_v[(c + RD_LAT + 1) % 16] = 1'b1;
          sch_d[(c + RD_LAT + 1) % 16] = m1[a];
        end else begin
          wq_k[(c + 2) % 16] = 1; wq_a[(c + 2) % 16] = a;
          wq_k[(c + 3) % 16] = 2; wq_a[(c + 3) % 16] = a;
        end
      end
      if (rsp_valid && nr < 32) begin
        r_cyc[nr] = c; r_d0[nr] = rsp_rdata0; r_d1[nr] = rsp_rdata1;
        nr++;
      end
    end
    l_sn[c % 64] = mem_strobe_n;
    l_rd[c % 64] = mem_rd_sel;
    l_addr[c % 64] = mem_addr;
    l_oe[c % 64] = mem_dq_oe;
    l_dq[c % 64] = mem_dq_out;
    l_we[c % 64] = mem_lane_we;
    l_rv[c % 64] = rsp_valid;
  end

  task automatic send(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d0,
                      input logic [DW-1:0] d1, input logic [LANES-1:0] k0,
                      input logic [LANES-1:0] k1, output int acc);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a;
    req_wdata0 = d0; req_wdata1 = d1; req_wmask0 = k0; req_wmask1 = k1;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    acc = cyc;
    if (wr) begin
      e0[a[3:0]] = merge(e0[a[3:0]], d0, k0);
      e1[a[3:0]] = merge(e1[a[3:0]], d1, k1);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_until(input int c);
    while (cyc <= c) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(mem_strobe_n === 1'b1, "R1", "strobe_n", 64'(mem_strobe_n), 64'd1);
    chk(mem_dq_oe === 1'b0, "R1", "oe", 64'(mem_dq_oe), 64'd0);
    chk(mem_lane_we === '0, "R1", "lane_we", 64'(mem_lane_we), 64'd0);
    chk(rsp_valid === 1'b0, "R1", "rsp_valid", 64'(rsp_valid), 64'd0);
    chk(k_slot === 1'b1, "R1", "k_slot", 64'(k_slot), 64'd1);
  endtask

  task automatic t_phase();
    logic prev;
    prev = k_slot;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); #1;
      chk(k_slot !== prev, "R2", "k_slot toggle", 64'(k_slot), 64'(!prev));
      chk(req_ready === !k_slot, "R2", "ready vs phase", 64'(req_ready), 64'(!k_slot));
      prev = k_slot;
    end
  endtask

  task automatic t_write_one();
    int a;
    send(1'b1, 8'h05, 18'h12345, 18'h2ABCD, 2'b11, 2'b01, a);
    wait_until(a + 6);
    chk(l_sn[(a + 1) % 64] == 1'b0, "R3", "write strobe", 64'(l_sn[(a + 1) % 64]), 64'd0);
    chk(l_rd[(a + 1) % 64] == 1'b0, "R3", "write select", 64'(l_rd[(a + 1) % 64]), 64'd0);
    chk(l_addr[(a + 1) % 64] == 8'h05, "R3", "write addr", 64'(l_addr[(a + 1) % 64]), 64'h5);
    chk(l_sn[(a + 2) % 64] == 1'b1, "R3", "no extra cmd", 64'(l_sn[(a + 2) % 64]), 64'd1);
    chk(l_oe[(a + 2) % 64] == 1'b0, "R4", "oe before data", 64'(l_oe[(a + 2) % 64]), 64'd0);
    chk(l_oe[(a + 3) % 64] && l_dq[(a + 3) % 64] == 18'h12345, "R4", "word0",
        64'(l_dq[(a + 3) % 64]), 64'h12345);
    chk(l_oe[(a + 4) % 64] && l_dq[(a + 4) % 64] == 18'h2ABCD, "R4", "word1",
        64'(l_dq[(a + 4) % 64]), 64'h2ABCD);
    chk(l_oe[(a + 5) % 64] == 1'b0, "R4", "oe after data", 64'(l_oe[(a + 5) % 64]), 64'd0);
    chk(l_we[(a + 3) % 64] == 2'b11, "R5", "mask word0", 64'(l_we[(a + 3) % 64]), 64'd3);
    chk(l_we[(a + 4) % 64] == 2'b01, "R5", "mask word1", 64'(l_we[(a + 4) % 64]), 64'd1);
  endtask

  task automatic t_read_one();
    int a, n0;
    n0 = nr;
    send(1'b0, 8'h05, '0, '0, '0, '0, a);
    wait_until(a + RD_LAT + 5);
    chk(l_sn[(a + 1) % 64] == 1'b0 && l_rd[(a + 1) % 64] == 1'b1, "R3", "read cmd",
        64'(l_rd[(a + 1) % 64]), 64'd1);
    chk(nr == n0 + 1, "R6", "one response", 64'(nr - n0), 64'd1);
    chk(r_cyc[n0] == a + RD_LAT + 3, "R6", "response cycle", 64'(r_cyc[n0]), 64'(a + RD_LAT + 3));
    chk(l_rv[(a + RD_LAT + 4) % 64] == 1'b0, "R6", "pulse width",
        64'(l_rv[(a + RD_LAT + 4) % 64]), 64'd0);
    chk(r_d0[n0] == e0[5], "R6", "read word0", 64'(r_d0[n0]), 64'(e0[5]));
    chk(r_d1[n0] == e1[5], "R5", "lane merged word1", 64'(r_d1[n0]), 64'(e1[5]));
  endtask

  task automatic t_turnaround();
    int aw, ar, ar2, aw2, n0;
    n0 = nr;
    send(1'b1, 8'h07, 18'h0F0F0, 18'h31313, 2'b10, 2'b11, aw);
    send(1'b0, 8'h07, '0, '0, '0, '0, ar);
    chk(ar - aw == DIFF_GAP, "R8", "write->read gap", 64'(ar - aw), 64'(DIFF_GAP));
    send(1'b0, 8'h03, '0, '0, '0, '0, ar2);
    chk(ar2 - ar == 2, "R7", "read->read gap", 64'(ar2 - ar), 64'd2);
    send(1'b1, 8'h09, 18'h00111, 18'h00222, 2'b01, 2'b10, aw2);
    chk(aw2 - ar2 == DIFF_GAP, "R8", "read->write gap", 64'(aw2 - ar2), 64'(DIFF_GAP));
    wait_until(aw2 + RD_LAT + 6);
    chk(nr == n0 + 2, "R9", "two responses", 64'(nr - n0), 64'd2);
    chk(r_d0[n0] == e0[7] && r_d1[n0] == e1[7], "R9", "first response addr7",
        64'(r_d0[n0]), 64'(e0[7]));
    chk(r_d0[n0 + 1] == e0[3] && r_d1[n0 + 1] == e1[3], "R9", "second response addr3",
        64'(r_d0[n0 + 1]), 64'(e0[3]));
  endtask

  task automatic t_stream();
    int a1, a2, b1, b2, b3, n0;
    send(1'b1, 8'h01, 18'h1AAAA, 18'h05555, 2'b11, 2'b11, a1);
    send(1'b1, 8'h02, 18'h26262, 18'h37373, 2'b01, 2'b10, a2);
    chk(a2 - a1 == 2, "R7", "write->write gap", 64'(a2 - a1), 64'd2);
    n0 = nr;
    send(1'b0, 8'h02, '0, '0, '0, '0, b1);
    send(1'b0, 8'h01, '0, '0, '0, '0, b2);
    send(1'b0, 8'h09, '0, '0, '0, '0, b3);
    chk(b3 - b1 == 4, "R7", "three reads spacing", 64'(b3 - b1), 64'd4);
    wait_until(b3 + RD_LAT + 5);
    chk(nr == n0 + 3, "R9", "three responses", 64'(nr - n0), 64'd3);
    chk(r_d0[n0] == e0[2] && r_d1[n0] == e1[2], "R9", "order 0", 64'(r_d1[n0]), 64'(e1[2]));
    chk(r_d0[n0 + 1] == e0[1] && r_d1[n0 + 1] == e1[1], "R9", "order 1",
        64'(r_d0[n0 + 1]), 64'(e0[1]));
    chk(r_d0[n0 + 2] == e0[9] && r_d1[n0 + 2] == e1[9], "R9", "order 2",
        64'(r_d0[n0 + 2]), 64'(e0[9]));
    chk(r_cyc[n0 + 1] - r_cyc[n0] == 2, "R6", "response spacing",
        64'(r_cyc[n0 + 1] - r_cyc[n0]), 64'd2);
  endtask

  task automatic t_idle();
    int c0;
    bit ok;
    c0 = cyc;
    wait_until(c0 + 12);
    ok = 1'b1;
    for (int i = c0 + 1; i <= c0 + 11; i++) if (l_sn[i % 64] !== 1'b1) ok = 1'b0;
    chk(ok, "R3", "strobe idle without requests", 64'(ok), 64'd1);
  endtask

  bit done = 1'b0;

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    #1;
    t_reset();
    t_phase();
    t_write_one();
    t_read_one();
    t_turnaround();
    t_stream();
    t_idle();
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule